// File: doc/BRIEF.md
# Indexed Extension-Word Address Calculator

This block turns an indexed addressing request into a 32-bit operand address. A request carries the 16-bit index extension word and a base value. The base is an address register, or the opcode address plus 4 for the PC-relative form; the caller selects which. While a request waits at the input, the block reads the index register through a combinational register-file read port. It then fetches any further extension words that hold base and outer displacements. When memory indirection is selected, it reads a 32-bit pointer as two 16-bit memory words. It ends with either an address or an error status.

Both the brief and the full extension-word formats are handled. The full format adds base suppression, displacements that are null, one word or two words long, and memory indirection with the index applied before the pointer read (pre-indexed), after it (post-indexed), or not at all. A fault on any fetch or pointer read stops the calculation. Register update and the operand transfer itself belong to the surrounding unit.

The request, extension-word fetch, memory read and result ports are all valid/ready channels. A request is taken only while the block is idle. A fetch or memory read stays asserted, with its address held, until the responder raises ready; the response data and fault flag are sampled in that same cycle. The result stays valid, with address and status held, until the consumer raises ready. The reset is asynchronous and active low.

Top module: `idx_ea_calc`

## Requirements
- R1: Brief format (ext[8]=0) gives address = base + sign-extended ext[7:0] + scaled index, with status 0 (OK), no extension fetch and no memory read. The result is valid one cycle after acceptance.
- R2: ext[15:12] selects one of 16 index registers on `rf_sel`. With ext[11]=0 only the low 16 bits of the register are used, sign-extended; with ext[11]=1 all 32 bits are used.
- R3: The index is shifted left by ext[10:9] (scale 1, 2, 4 or 8) in both formats.
- R4: In the full format (ext[8]=1), ext[7]=1 replaces the base with zero.
- R5: The base displacement size is ext[5:4]: 0 or 1 null, 2 one word sign-extended, 3 two words with the high word first.
- R6: The outer field ext[1:0] is 0 for no indirection, where address = base + base displacement, plus the index only when pre-indexed; a post-indexed index is then not applied. Values 1, 2 and 3 select indirection with a null, one-word or two-word outer displacement. Base displacement words are fetched before outer ones.
- R7: {ext[6],ext[2]} = 00 pre-indexed, 01 post-indexed, 10 no index. Pattern 11, or ext[3]=1, in the full format is illegal: status 2, no fetch, result one cycle after acceptance.
- R8: With indirection, the pointer is read at inner = base + base displacement (+ index if pre-indexed), high word at inner and low word at inner+2. The address is then pointer + outer displacement (+ index if post-indexed).
- R9: A fault flag on any extension fetch or pointer read ends the calculation with status 1. No further access is made.
- R10: `req_ready` is high only while idle. A fetch or memory request, and a result, hold their valid and payload until accepted.
- R11: After reset the block is idle: `req_ready`=1, and `xw_valid`, `mem_valid` and `res_valid` are 0.
- R12: `res_addr` is zero whenever the status is not OK.
- R13: Each accepted fetch or read takes one cycle. With responders always ready, the result comes 1 + (number of accesses) cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_ext | input | 16 | Index extension word |
| req_base | input | 32 | Base value (address register or PC+4) |
| rf_sel | output | 4 | Index register select |
| rf_data | input | 32 | Selected register contents |
| xw_valid | output | 1 | Extension word fetch request |
| xw_ready | input | 1 | Fetch response present this cycle |
| xw_data | input | 16 | Fetched extension word |
| xw_fault | input | 1 | Fetch faulted |
| mem_valid | output | 1 | Pointer word read request |
| mem_addr | output | 32 | Pointer word address |
| mem_ready | input | 1 | Read response present this cycle |
| mem_data | input | 16 | Read word |
| mem_fault | input | 1 | Read faulted |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_addr | output | 32 | Effective address |
| res_status | output | 2 | 0 OK, 1 fault, 2 illegal |

## Verification
A brief or illegal word gives a result one cycle after acceptance. Every other request adds one cycle per granted extension fetch or pointer read, so the result is due at 1 + accesses cycles. The bench drives and samples on the falling edge. Each cycle it compares every fetch and read request against a queue of expected accesses built behaviourally from the word, and it checks the result exactly at its due cycle when responders never stall. In stalled runs it checks order and content only, plus the hold of each payload while ready is low.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;
  localparam int EXT_W = 16;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_FAULT   = 2'd1,
    ST_ILLEGAL = 2'd2
  } ea_status_e;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'd0,
    SZ_NULL = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LONG = 2'd3
  } disp_size_e;

  typedef enum logic [1:0] {
    IX_PRE  = 2'd0,
    IX_POST = 2'd1,
    IX_NONE = 2'd2,
    IX_BAD  = 2'd3
  } ix_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0] reg_sel;
    logic             idx_long;
    logic [1:0]       scale;
    logic             full;
    logic             base_off;
    disp_size_e       bd_sz;
    disp_size_e       od_sz;
    ix_mode_e         ix;
    logic             bad;
    logic [7:0]       d8;
  } ext_fields_t;

  typedef struct packed {
    logic       base_off;
    disp_size_e bd_sz;
    disp_size_e od_sz;
    ix_mode_e   ix;
  } mode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BD_HI,
    S_BD_LO,
    S_OD_HI,
    S_OD_LO,
    S_PTR_HI,
    S_PTR_LO,
    S_DONE
  } state_e;

  function automatic state_e after_bd(disp_size_e od);
    case (od)
      SZ_WORD: return S_OD_LO;
      SZ_LONG: return S_OD_HI;
      SZ_NULL: return S_PTR_HI;
      default: return S_DONE;
    endcase
  endfunction

  function automatic state_e first_step(ext_fields_t f);
    if (!f.full || f.bad) return S_DONE;
    case (f.bd_sz)
      SZ_WORD: return S_BD_LO;
      SZ_LONG: return S_BD_HI;
      default: return after_bd(f.od_sz);
    endcase
  endfunction
endpackage

// File: rtl/idx_ea_decode.sv
module idx_ea_decode
  import idx_ea_pkg::*;
(
  input  logic [EXT_W-1:0] ext_i,
  output ext_fields_t      fld_o
);
  always_comb begin
    fld_o.reg_sel  = ext_i[15:12];
    fld_o.idx_long = ext_i[11];
    fld_o.scale    = ext_i[10:9];
    fld_o.full     = ext_i[8];
    fld_o.d8       = ext_i[7:0];
    if (ext_i[8]) begin
      fld_o.base_off = ext_i[7];
      fld_o.bd_sz    = disp_size_e'(ext_i[5:4]);
      fld_o.od_sz    = disp_size_e'(ext_i[1:0]);
      fld_o.ix       = ix_mode_e'({ext_i[6], ext_i[2]});
      fld_o.bad      = ext_i[3] || (ext_i[6] && ext_i[2]);
    end else begin
      // brief word: base kept, index always joins before any use
      fld_o.base_off = 1'b0;
      fld_o.bd_sz    = SZ_NULL;
      fld_o.od_sz    = SZ_RSVD;
      fld_o.ix       = IX_PRE;
      fld_o.bad      = 1'b0;
    end
  end
endmodule

// File: rtl/idx_ea_scale.sv
module idx_ea_scale #(
  parameter int ADDR_W  = 32,
  parameter int HALF_W  = 16,
  parameter int N_SCALE = 4
) (
  input  logic [ADDR_W-1:0]          reg_i,
  input  logic                       long_i,
  input  logic [$clog2(N_SCALE)-1:0] scale_i,
  output logic [ADDR_W-1:0]          idx_o
);
  logic [ADDR_W-1:0] widened;
  logic [ADDR_W-1:0] shifted [N_SCALE];

  always_comb widened = long_i ? reg_i : ADDR_W'($signed(reg_i[HALF_W-1:0]));

  for (genvar s = 0; s < N_SCALE; s++) begin : g_shift
    assign shifted[s] = widened << s;
  end

  assign idx_o = shifted[scale_i];
endmodule

// File: rtl/idx_ea_sum.sv
module idx_ea_sum
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              base_off_i,
  input  logic [ADDR_W-1:0] bd_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  ix_mode_e          ix_i,
  input  disp_size_e        od_sz_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] od_i,
  output logic [ADDR_W-1:0] inner_o,
  output logic [ADDR_W-1:0] final_o
);
  logic [ADDR_W-1:0] base_eff, pre_term, post_term, outer;

  always_comb begin
    base_eff  = base_off_i ? '0 : base_i;
    pre_term  = (ix_i == IX_PRE)  ? idx_i : '0;
    post_term = (ix_i == IX_POST) ? idx_i : '0;
    inner_o   = base_eff + bd_i + pre_term;
    outer     = ptr_i + od_i + post_term;
    final_o   = (od_sz_i != SZ_RSVD) ? outer : inner_o;
  end
endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
  import idx_ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = EXT_W,
  parameter int N_REG  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [WORD_W-1:0]        req_ext,
  input  logic [ADDR_W-1:0]        req_base,
  output logic [$clog2(N_REG)-1:0] rf_sel,
  input  logic [ADDR_W-1:0]        rf_data,
  output logic                     xw_valid,
  input  logic                     xw_ready,
  input  logic [WORD_W-1:0]        xw_data,
  input  logic                     xw_fault,
  output logic                     mem_valid,
  output logic [ADDR_W-1:0]        mem_addr,
  input  logic                     mem_ready,
  input  logic [WORD_W-1:0]        mem_data,
  input  logic                     mem_fault,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [ADDR_W-1:0]        res_addr,
  output logic [1:0]               res_status
);
  localparam int WORD_BYTES = WORD_W / 8;

  ext_fields_t       dec_in;
  logic [ADDR_W-1:0] idx_scaled;

  state_e            state_q;
  mode_t             mode_q;
  ea_status_e        status_q;
  logic [ADDR_W-1:0] base_q, idx_q, bd_q, od_q, ptr_q;
  logic [ADDR_W-1:0] inner, final_addr;

  idx_ea_decode u_decode (
    .ext_i (req_ext),
    .fld_o (dec_in)
  );

  assign rf_sel = dec_in.reg_sel;

  idx_ea_scale #(.ADDR_W(ADDR_W), .HALF_W(WORD_W), .N_SCALE(4)) u_scale (
    .reg_i   (rf_data),
    .long_i  (dec_in.idx_long),
    .scale_i (dec_in.scale),
    .idx_o   (idx_scaled)
  );

  idx_ea_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base_i     (base_q),
    .base_off_i (mode_q.base_off),
    .bd_i       (bd_q),
    .idx_i      (idx_q),
    .ix_i       (mode_q.ix),
    .od_sz_i    (mode_q.od_sz),
    .ptr_i      (ptr_q),
    .od_i       (od_q),
    .inner_o    (inner),
    .final_o    (final_addr)
  );

  // low word of a displacement: either a whole word (sign-extended)
  // or the tail of a two-word value whose high half is already held
  function automatic logic [ADDR_W-1:0] take_low(input logic is_word,
                                                 input logic [ADDR_W-1:0] acc,
                                                 input logic [WORD_W-1:0] w);
    if (is_word) return ADDR_W'($signed(w));
    return {acc[ADDR_W-1:WORD_W], w};
  endfunction

  assign req_ready  = (state_q == S_IDLE);
  assign xw_valid   = (state_q == S_BD_HI) || (state_q == S_BD_LO) ||
                      (state_q == S_OD_HI) || (state_q == S_OD_LO);
  assign mem_valid  = (state_q == S_PTR_HI) || (state_q == S_PTR_LO);
  assign mem_addr   = inner + ((state_q == S_PTR_LO) ? ADDR_W'(WORD_BYTES) : '0);
  assign res_valid  = (state_q == S_DONE);
  assign res_status = status_q;
  assign res_addr   = (status_q == ST_OK) ? final_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mode_q   <= '0;
      status_q <= ST_OK;
      base_q   <= '0;
      idx_q    <= '0;
      bd_q     <= '0;
      od_q     <= '0;
      ptr_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            mode_q   <= '{base_off: dec_in.base_off, bd_sz: dec_in.bd_sz,
                          od_sz: dec_in.od_sz, ix: dec_in.ix};
            base_q   <= req_base;
            idx_q    <= idx_scaled;
            bd_q     <= dec_in.full ? '0 : ADDR_W'($signed(dec_in.d8));
            od_q     <= '0;
            ptr_q    <= '0;
            status_q <= dec_in.bad ? ST_ILLEGAL : ST_OK;
            state_q  <= first_step(dec_in);
          end
        end
        S_BD_HI: begin
          if (xw_ready) begin
            if (xw_fault) begin
              status_q <= ST_FAULT;
              state_q  <= S_DONE;
            end else begin
              bd_q    <= ADDR_W'(xw_data) << WORD_W;
              state_q <= S_BD_LO;
            end
          end
        end
        S_BD_LO: begin
          if (xw_ready) begin
            if (xw_fault) begin
              status_q <= ST_FAULT;
              state_q  <= S_DONE;
            end else begin
              bd_q    <= take_low(mode_q.bd_sz == SZ_WORD, bd_q, xw_data);
              state_q <= after_bd(mode_q.od_sz);
            end
          end
        end
        S_OD_HI: begin
          if (xw_ready) begin
            if (xw_fault) begin
              status_q <= ST_FAULT;
              state_q  <= S_DONE;
            end else begin
              od_q    <= ADDR_W'(xw_data) << WORD_W;
              state_q <= S_OD_LO;
            end
          end
        end
        S_OD_LO: begin
          if (xw_ready) begin
            if (xw_fault) begin
              status_q <= ST_FAULT;
              state_q  <= S_DONE;
            end else begin
              od_q    <= take_low(mode_q.od_sz == SZ_WORD, od_q, xw_data);
              state_q <= S_PTR_HI;
            end
          end
        end
        S_PTR_HI: begin
          if (mem_ready) begin
            if (mem_fault) begin
              status_q <= ST_FAULT;
              state_q  <= S_DONE;
            end else begin
              ptr_q   <= ADDR_W'(mem_data) << WORD_W;
              state_q <= S_PTR_LO;
            end
          end
        end
        S_PTR_LO: begin
          if (mem_ready) begin
            if (mem_fault) begin
              status_q <= ST_FAULT;
            end else begin
              ptr_q <= {ptr_q[ADDR_W-1:WORD_W], mem_data};
            end
            state_q <= S_DONE;
          end
        end
        S_DONE: begin
          if (res_ready) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_ea_calc_chk.sv
module idx_ea_calc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              is_full,
  input logic              is_bad,
  input logic              xw_valid,
  input logic              xw_ready,
  input logic              xw_fault,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_addr,
  input logic [1:0]        res_status
);
  p_single_channel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xw_valid, mem_valid, res_valid}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !xw_valid && !mem_valid && !res_valid);

  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_status));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  p_xw_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xw_valid && !xw_ready |=> xw_valid);

  p_zero_addr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_status != 2'd0) |-> res_addr == '0);

  p_brief_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_full |=> res_valid && res_status == 2'd0);

  p_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && is_full && is_bad |=> res_valid && res_status == 2'd2);

  p_fetch_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    xw_valid && xw_ready && xw_fault |=> res_valid && res_status == 2'd1);
endmodule

bind idx_ea_calc idx_ea_calc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (req_valid && req_ready),
  .is_full    (req_ext[8]),
  .is_bad     (req_ext[3] || (req_ext[6] && req_ext[2])),
  .xw_valid   (xw_valid),
  .xw_ready   (xw_ready),
  .xw_fault   (xw_fault),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .req_ready  (req_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_addr   (res_addr),
  .res_status (res_status)
);

// File: tb/idx_ea_calc_tb.sv
module idx_ea_calc_tb;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [15:0]   req_ext = '0;
  logic [AW-1:0] req_base = '0;
  logic [3:0]    rf_sel;
  logic [AW-1:0] rf_data;
  logic          xw_valid;
  logic          xw_ready = 1'b0;
  logic [15:0]   xw_data = '0;
  logic          xw_fault = 1'b0;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b0;
  logic [15:0]   mem_data = '0;
  logic          mem_fault = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [AW-1:0] res_addr;
  logic [1:0]    res_status;

  logic [AW-1:0] regs [16];
  assign rf_data = regs[rf_sel];

  int n_chk = 0;
  int n_err = 0;

  idx_ea_calc u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ext(req_ext), .req_base(req_base),
    .rf_sel(rf_sel), .rf_data(rf_data),
    .xw_valid(xw_valid), .xw_ready(xw_ready), .xw_data(xw_data), .xw_fault(xw_fault),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_data(mem_data), .mem_fault(mem_fault),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr), .res_status(res_status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural model: build the expected access list and result, then
  // serve and compare every cycle
  task automatic run(input string nm, input string rq, input logic [15:0] ext,
                     input logic [31:0] base, input logic [31:0] bdv,
                     input logic [31:0] odv, input logic [31:0] ptr,
                     input int fault_at, input bit stall);
    bit          kind [$];
    logic [15:0] wd [$];
    logic [31:0] ad [$];
    logic [31:0] ri, ix, b, bdx, odx, inner, exp_addr;
    logic [1:0]  exp_st;
    int n, k, cyc;
    bit go;
    ri = regs[ext[15:12]];
    ix = ext[11] ? ri : {{16{ri[15]}}, ri[15:0]};
    ix = ix << ext[10:9];
    exp_st = 2'd0;
    if (!ext[8]) begin
      exp_addr = base + {{24{ext[7]}}, ext[7:0]} + ix;
    end else if (ext[3] || (ext[6] && ext[2])) begin
      exp_st = 2'd2;
      exp_addr = '0;
    end else begin
      b = ext[7] ? 32'd0 : base;
      bdx = '0;
      if (ext[5:4] == 2'd2) begin
        bdx = {{16{bdv[15]}}, bdv[15:0]};
        kind.push_back(1'b0); wd.push_back(bdv[15:0]); ad.push_back('0);
      end else if (ext[5:4] == 2'd3) begin
        bdx = bdv;
        kind.push_back(1'b0); wd.push_back(bdv[31:16]); ad.push_back('0);
        kind.push_back(1'b0); wd.push_back(bdv[15:0]);  ad.push_back('0);
      end
      odx = '0;
      if (ext[1:0] == 2'd2) begin
        odx = {{16{odv[15]}}, odv[15:0]};
        kind.push_back(1'b0); wd.push_back(odv[15:0]); ad.push_back('0);
      end else if (ext[1:0] == 2'd3) begin
        odx = odv;
        kind.push_back(1'b0); wd.push_back(odv[31:16]); ad.push_back('0);
        kind.push_back(1'b0); wd.push_back(odv[15:0]);  ad.push_back('0);
      end
      inner = b + bdx + ((!ext[6] && !ext[2]) ? ix : 32'd0);
      if (ext[1:0] == 2'd0) begin
        exp_addr = inner;
      end else begin
        kind.push_back(1'b1); wd.push_back(ptr[31:16]); ad.push_back(inner);
        kind.push_back(1'b1); wd.push_back(ptr[15:0]);  ad.push_back(inner + 32'd2);
        exp_addr = ptr + odx + ((!ext[6] && ext[2]) ? ix : 32'd0);
      end
    end
    n = kind.size();
    if (fault_at >= 0 && fault_at < n) begin
      n = fault_at + 1;
      exp_st = 2'd1;
      exp_addr = '0;
    end

    @(negedge clk);
    chk(req_ready === 1'b1, "R10", {nm, " ready when idle"}, {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_ext = ext; req_base = base;
    @(negedge clk);
    req_valid = 1'b0; req_ext = '0; req_base = '0;
    cyc = 1;
    k = 0;
    while (1) begin
      xw_ready = 1'b0; mem_ready = 1'b0; xw_fault = 1'b0; mem_fault = 1'b0;
      if (res_valid === 1'b1) break;
      if (cyc > 100) begin
        chk(1'b0, "R13", {nm, " no result"}, cyc, 1 + n);
        break;
      end
      go = !stall || (cyc % 2 == 0);
      if (xw_valid === 1'b1) begin
        if (k >= n || kind[k] != 1'b0) begin
          chk(1'b0, "R9", {nm, " unexpected extension fetch"}, k, n);
          xw_ready = 1'b1; xw_data = '0;
        end else if (go) begin
          xw_ready = 1'b1; xw_data = wd[k]; xw_fault = (k == fault_at); k++;
        end
      end else if (mem_valid === 1'b1) begin
        if (k >= n || kind[k] != 1'b1) begin
          chk(1'b0, "R9", {nm, " unexpected pointer read"}, k, n);
          mem_ready = 1'b1; mem_data = '0;
        end else begin
          chk(mem_addr === ad[k], "R8", {nm, " pointer read address"}, mem_addr, ad[k]);
          if (go) begin
            mem_ready = 1'b1; mem_data = wd[k]; mem_fault = (k == fault_at); k++;
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    chk(k == n, "R9", {nm, " access count"}, k, n);
    if (!stall) chk(cyc == 1 + n, "R13", {nm, " result cycle"}, cyc, 1 + n);
    chk(res_status === exp_st, rq, {nm, " status"}, {30'd0, res_status}, {30'd0, exp_st});
    chk(res_addr === exp_addr, (exp_st != 2'd0) ? "R12" : rq, {nm, " address"}, res_addr, exp_addr);
    if (stall) begin
      repeat (3) begin
        @(negedge clk);
        chk(res_valid === 1'b1 && res_addr === exp_addr, "R10", {nm, " result held"},
            res_addr, exp_addr);
      end
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid === 1'b0 && req_ready === 1'b1, "R10", {nm, " back to idle"},
        {30'd0, res_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R13", "watchdog expired", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0101_0101 * i;
    regs[3]  = 32'h1234_8010;
    regs[10] = 32'h0000_0100;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && xw_valid === 1'b0 && mem_valid === 1'b0 && res_valid === 1'b0,
        "R11", "state during reset", {28'd0, req_ready, xw_valid, mem_valid, res_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && res_valid === 1'b0, "R11", "idle after reset",
        {30'd0, req_ready, res_valid}, 32'h2);

    run("brief word index",      "R2", 16'h3010, 32'h1000_0000, 0, 0, 0, -1, 1'b0);
    run("brief scaled long idx", "R3", 16'h3CF0, 32'h1000_0000, 0, 0, 0, -1, 1'b0);
    run("brief scale 8",         "R1", 16'hAE7F, 32'h0000_2000, 0, 0, 0, -1, 1'b0);
    run("full word bd pre",      "R5", 16'hAB20, 32'h0004_0000, 32'h0000_8004, 0, 0, -1, 1'b0);
    run("suppressed base long",  "R4", 16'h01F0, 32'h7777_0000, 32'h1234_5678, 0, 0, -1, 1'b0);
    run("pre-indexed indirect",  "R8", 16'hA923, 32'h0000_3000, 32'h0000_0010, 32'h0000_1000,
        32'h4000_0000, -1, 1'b0);
    run("post-indexed indirect", "R6", 16'h3316, 32'h0000_5000, 0, 32'h0000_FFFE,
        32'h2000_0000, -1, 1'b0);
    run("null outer indirect",   "R6", 16'h0141, 32'h0000_6000, 0, 0, 32'hDEAD_BEEE, -1, 1'b0);
    run("post index no indir",   "R6", 16'hA924, 32'h0000_7000, 32'h0000_0008, 0, 0, -1, 1'b0);
    run("illegal index pattern", "R7", 16'h0144, 32'h0000_1000, 0, 0, 0, -1, 1'b0);
    run("illegal bit 3",         "R7", 16'h010B, 32'h0000_1000, 0, 0, 0, -1, 1'b0);
    run("fault on bd low",       "R9", 16'h01F0, 32'h0, 32'h1234_5678, 0, 0, 1, 1'b0);
    run("fault on pointer low",  "R9", 16'hA923, 32'h0000_3000, 32'h0000_0010, 32'h0000_1000,
        32'h4000_0000, 4, 1'b0);
    run("fault on pointer high", "R9", 16'h3316, 32'h0000_5000, 0, 32'h0000_FFFE,
        32'h2000_0000, 1, 1'b0);
    run("stalled pre-indexed",   "R10", 16'hA923, 32'h0000_3000, 32'h0000_0010, 32'h0000_1000,
        32'h4000_0000, -1, 1'b1);
    run("stalled post-indexed",  "R10", 16'h3316, 32'h0000_5000, 0, 32'h0000_FFFE,
        32'h2000_0000, -1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule